// File: doc/BRIEF.md
# Indirect I/O Register Access Window

This block exposes a small I/O-mapped slave with two registers. A pointer register, selected with `h_sel = 0`, holds a 20-bit target address. A window register, selected with `h_sel = 1`, turns each host access into one request on an internal bus. Software first loads the pointer and then touches the window. The window forwards the access to the internal register and memory space or to the flash region, and it returns a full 32-bit word on every read.

Before it issues a request, the block decodes the region of the held address. It checks the access size against that region and checks the active-low byte enables against the low address bits. A legal access becomes exactly one valid/ready request that carries per-byte active-high strobes. The host interface keeps `h_ready` low until that request has finished. An illegal access never reaches the internal bus: it sets a sticky error flag, and if it is a read it returns all ones.

Top module: `ioport_window`

## Requirements
- R1: After reset the pointer reads as 0, `h_ready` is 1, `err` is 0, `h_rvalid` is 0 and `t_req_valid` is 0.
- R2: A host write with `h_sel = 0` loads `h_wdata[19:0]` into the pointer. If bits [19:17] of the value are zero, bits [1:0] are stored as zero; otherwise they are kept. A host read with `h_sel = 0` returns the pointer zero-extended, with `h_rvalid` high in the cycle after acceptance.
- R3: The held pointer selects a region. Bits [19:17] all zero select the register space (0x00000 to 0x1FFFF). Bit 19 set selects flash (0x80000 to 0xFFFFF). Every other value is undefined.
- R4: In the register space, a window write with `h_be_n = 4'b0000` issues one write request with strobe 4'b1111 and an address whose bits [1:0] are 00. A window write with any other `h_be_n` is dropped silently: no request is issued and `err` does not change.
- R5: In flash, a window write is legal only for these pairs of address bits [1:0] and `h_be_n`: 00/1110, 01/1101, 10/1011, 11/0111, 00/1100, 10/0011, 00/0000. A legal write issues one request with strobe `~h_be_n`, the held address unchanged, and the host data.
- R6: In flash, a window read or write with any other pair issues no request and sets `err`. Such a read returns 0xFFFFFFFF.
- R7: Any window access while the pointer is in the undefined region issues no request and sets `err`. Such a read returns 0xFFFFFFFF.
- R8: A window read in the register space (with any `h_be_n`), or a legal window read in flash, issues a read request. In the register space its strobe is 4'b1111; in flash it is `~h_be_n`. The host receives the full returned word `t_rsp_data` with `h_rvalid` high in the cycle after `t_rsp_valid`.
- R9: Once raised, `t_req_valid` and every request field stay stable until `t_req_ready`. `h_ready` is low from the cycle after a forwarded window access until the request completes: for a write, one cycle after the request handshake; for a read, one cycle after `t_rsp_valid`.
- R10: `err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_valid | input | 1 | Host access request |
| h_ready | output | 1 | Host access may be accepted |
| h_sel | input | 1 | 0 selects the pointer register, 1 selects the window |
| h_write | input | 1 | 1 for a write, 0 for a read |
| h_be_n | input | 4 | Active-low byte enables |
| h_wdata | input | 32 | Host write data |
| h_rvalid | output | 1 | Read data valid pulse |
| h_rdata | output | 32 | Read data |
| t_req_valid | output | 1 | Internal request valid |
| t_req_ready | input | 1 | Internal request accepted |
| t_req_addr | output | 20 | Internal request address |
| t_req_write | output | 1 | Internal request is a write |
| t_req_strb | output | 4 | Active-high byte strobes |
| t_req_wdata | output | 32 | Internal write data |
| t_rsp_valid | input | 1 | Internal read data valid |
| t_rsp_data | input | 32 | Internal read data |
| err | output | 1 | Sticky illegal-access flag |

## Verification
Some properties can be checked on every cycle, and the assertions cover them: requests hold stable under back-pressure, the host side stalls while a request is open, no request ever targets the undefined region, register-space writes are full-word and aligned, and the error flag is sticky. Other behaviour only shows in the bench scenarios. These are the pointer alignment rule, the complete flash legality table, the silent dropping of short register writes, the all-ones read on an illegal access, and the return of internal read data under varied stall and latency. The bench checks them against its own region and lane tables, and it compares the error flag with a behavioural model on every clock.

// File: rtl/ioport_pkg.sv
package ioport_pkg;
  typedef enum logic [1:0] {
    RGN_REG   = 2'd0,
    RGN_FLASH = 2'd1,
    RGN_UNDEF = 2'd2
  } region_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } wstate_e;
endpackage

// File: rtl/ioport_decode.sv
module ioport_decode
  import ioport_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int BE_W       = 4,
  parameter int REG_SPAN_W = 17
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be_n,
  output region_e           region,
  output logic              lanes_ok,
  output logic              full
);
  localparam int LW = $clog2(BE_W);
  localparam int NSZ = LW + 1;

  logic [BE_W-1:0] strb;
  logic [LW-1:0]   lo;
  logic [NSZ-1:0]  hit;

  assign strb = ~be_n;
  assign lo   = addr[LW-1:0];
  assign full = (be_n == '0);

  always_comb begin
    if (addr[ADDR_W-1])
      region = RGN_FLASH;
    else if (addr[ADDR_W-1:REG_SPAN_W] == '0)
      region = RGN_REG;
    else
      region = RGN_UNDEF;
  end

  for (genvar k = 0; k < NSZ; k++) begin : g_size
    localparam int SZ = 1 << k;
    logic [2*BE_W-1:0] mask;
    assign mask   = {{(2*BE_W-SZ){1'b0}}, {SZ{1'b1}}} << lo;
    assign hit[k] = ((lo & LW'(SZ-1)) == '0) && (mask == {{BE_W{1'b0}}, strb});
  end

  assign lanes_ok = |hit;
endmodule

// File: rtl/ioport_addr_reg.sv
module ioport_addr_reg #(
  parameter int ADDR_W     = 20,
  parameter int LW         = 2,
  parameter int REG_SPAN_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wval,
  output logic [ADDR_W-1:0] addr_q
);
  logic in_reg;
  assign in_reg = (wval[ADDR_W-1:REG_SPAN_W] == '0);

  always_ff @(posedge clk) begin
    if (rst)
      addr_q <= '0;
    else if (we)
      addr_q <= in_reg ? {wval[ADDR_W-1:LW], {LW{1'b0}}} : wval;
  end
endmodule

// File: rtl/ioport_ctrl.sv
module ioport_ctrl
  import ioport_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              h_valid,
  input  logic              h_sel,
  input  logic              h_write,
  input  logic [BE_W-1:0]   h_be_n,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic [ADDR_W-1:0] addr_q,
  input  region_e           region,
  input  logic              lanes_ok,
  input  logic              full,
  output logic              addr_we,
  output logic              h_ready,
  output logic              h_rvalid,
  output logic [DATA_W-1:0] h_rdata,
  output logic              t_req_valid,
  input  logic              t_req_ready,
  output logic [ADDR_W-1:0] t_req_addr,
  output logic              t_req_write,
  output logic [BE_W-1:0]   t_req_strb,
  output logic [DATA_W-1:0] t_req_wdata,
  input  logic              t_rsp_valid,
  input  logic [DATA_W-1:0] t_rsp_data,
  output logic              err
);
  wstate_e state;
  logic acc, data_acc, bad, go;

  assign acc      = h_valid && h_ready;
  assign addr_we  = acc && !h_sel && h_write;
  assign data_acc = acc && h_sel;
  assign bad      = (region == RGN_UNDEF) || ((region == RGN_FLASH) && !lanes_ok);
  assign go       = data_acc && !bad && ((region == RGN_FLASH) || !h_write || full);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      h_ready     <= 1'b1;
      h_rvalid    <= 1'b0;
      h_rdata     <= '0;
      t_req_valid <= 1'b0;
      t_req_addr  <= '0;
      t_req_write <= 1'b0;
      t_req_strb  <= '0;
      t_req_wdata <= '0;
      err         <= 1'b0;
    end else begin
      h_rvalid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (acc && !h_sel && !h_write) begin
            h_rvalid <= 1'b1;
            h_rdata  <= {{(DATA_W-ADDR_W){1'b0}}, addr_q};
          end
          if (data_acc && bad) begin
            err <= 1'b1;
            if (!h_write) begin
              h_rvalid <= 1'b1;
              h_rdata  <= '1;
            end
          end
          if (go) begin
            state       <= ST_REQ;
            h_ready     <= 1'b0;
            t_req_valid <= 1'b1;
            t_req_addr  <= addr_q;
            t_req_write <= h_write;
            t_req_strb  <= (region == RGN_REG) ? '1 : ~h_be_n;
            t_req_wdata <= h_wdata;
          end
        end
        ST_REQ: begin
          if (t_req_ready) begin
            t_req_valid <= 1'b0;
            if (t_req_write) begin
              state   <= ST_IDLE;
              h_ready <= 1'b1;
            end else begin
              state <= ST_RSP;
            end
          end
        end
        ST_RSP: begin
          if (t_rsp_valid) begin
            state    <= ST_IDLE;
            h_ready  <= 1'b1;
            h_rvalid <= 1'b1;
            h_rdata  <= t_rsp_data;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ioport_window.sv
module ioport_window
  import ioport_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 32,
  parameter int REG_SPAN_W = 17
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                h_valid,
  output logic                h_ready,
  input  logic                h_sel,
  input  logic                h_write,
  input  logic [DATA_W/8-1:0] h_be_n,
  input  logic [DATA_W-1:0]   h_wdata,
  output logic                h_rvalid,
  output logic [DATA_W-1:0]   h_rdata,
  output logic                t_req_valid,
  input  logic                t_req_ready,
  output logic [ADDR_W-1:0]   t_req_addr,
  output logic                t_req_write,
  output logic [DATA_W/8-1:0] t_req_strb,
  output logic [DATA_W-1:0]   t_req_wdata,
  input  logic                t_rsp_valid,
  input  logic [DATA_W-1:0]   t_rsp_data,
  output logic                err
);
  localparam int BE_W = DATA_W / 8;
  localparam int LW   = $clog2(BE_W);

  logic [ADDR_W-1:0] addr_q;
  logic              addr_we;
  region_e           region;
  logic              lanes_ok, full;

  ioport_addr_reg #(.ADDR_W(ADDR_W), .LW(LW), .REG_SPAN_W(REG_SPAN_W)) areg_i (
    .clk(clk), .rst(rst), .we(addr_we), .wval(h_wdata[ADDR_W-1:0]), .addr_q(addr_q)
  );

  ioport_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W), .REG_SPAN_W(REG_SPAN_W)) dec_i (
    .addr(addr_q), .be_n(h_be_n), .region(region), .lanes_ok(lanes_ok), .full(full)
  );

  ioport_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) ctrl_i (
    .clk(clk), .rst(rst), .h_valid(h_valid), .h_sel(h_sel), .h_write(h_write),
    .h_be_n(h_be_n), .h_wdata(h_wdata), .addr_q(addr_q), .region(region),
    .lanes_ok(lanes_ok), .full(full), .addr_we(addr_we), .h_ready(h_ready),
    .h_rvalid(h_rvalid), .h_rdata(h_rdata), .t_req_valid(t_req_valid),
    .t_req_ready(t_req_ready), .t_req_addr(t_req_addr), .t_req_write(t_req_write),
    .t_req_strb(t_req_strb), .t_req_wdata(t_req_wdata), .t_rsp_valid(t_rsp_valid),
    .t_rsp_data(t_rsp_data), .err(err)
  );
endmodule

// File: rtl/ioport_window_chk.sv
module ioport_window_chk #(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 32,
  parameter int REG_SPAN_W = 17
) (
  input logic                clk,
  input logic                rst,
  input logic                h_ready,
  input logic                h_rvalid,
  input logic                t_req_valid,
  input logic                t_req_ready,
  input logic [ADDR_W-1:0]   t_req_addr,
  input logic                t_req_write,
  input logic [DATA_W/8-1:0] t_req_strb,
  input logic [DATA_W-1:0]   t_req_wdata,
  input logic                err
);
  logic req_in_reg, req_in_undef;
  assign req_in_reg   = (t_req_addr[ADDR_W-1:REG_SPAN_W] == '0);
  assign req_in_undef = !t_req_addr[ADDR_W-1] && !req_in_reg;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (h_ready && !t_req_valid && !err && !h_rvalid));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (t_req_valid && !t_req_ready) |=> (t_req_valid && $stable(t_req_addr) &&
      $stable(t_req_strb) && $stable(t_req_write) && $stable(t_req_wdata)));

  assert_stall_R9: assert property (@(posedge clk) disable iff (rst)
    t_req_valid |-> !h_ready);

  assert_full_write_R4: assert property (@(posedge clk) disable iff (rst)
    (t_req_valid && t_req_write && req_in_reg) |->
      ((t_req_strb == '1) && (t_req_addr[1:0] == 2'b00)));

  assert_no_undef_R7: assert property (@(posedge clk) disable iff (rst)
    t_req_valid |-> !req_in_undef);

  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  assert_rvalid_ready_R8: assert property (@(posedge clk) disable iff (rst)
    h_rvalid |-> h_ready);
endmodule

bind ioport_window ioport_window_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_SPAN_W(REG_SPAN_W)
) chk_i (
  .clk(clk), .rst(rst), .h_ready(h_ready), .h_rvalid(h_rvalid),
  .t_req_valid(t_req_valid), .t_req_ready(t_req_ready), .t_req_addr(t_req_addr),
  .t_req_write(t_req_write), .t_req_strb(t_req_strb), .t_req_wdata(t_req_wdata),
  .err(err)
);

// File: tb/ioport_window_tb_top.sv
module ioport_window_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_valid = 1'b0, h_sel = 1'b0, h_write = 1'b0;
  logic [3:0]  h_be_n = 4'hF;
  logic [31:0] h_wdata = '0;
  logic        h_ready, h_rvalid, err;
  logic [31:0] h_rdata;
  logic        t_req_valid, t_req_write;
  logic        t_req_ready = 1'b0;
  logic [19:0] t_req_addr;
  logic [3:0]  t_req_strb;
  logic [31:0] t_req_wdata;
  logic        t_rsp_valid = 1'b0;
  logic [31:0] t_rsp_data = '0;

  always #5 clk = ~clk;

  ioport_window dut_i (
    .clk(clk), .rst(rst), .h_valid(h_valid), .h_ready(h_ready), .h_sel(h_sel),
    .h_write(h_write), .h_be_n(h_be_n), .h_wdata(h_wdata), .h_rvalid(h_rvalid),
    .h_rdata(h_rdata), .t_req_valid(t_req_valid), .t_req_ready(t_req_ready),
    .t_req_addr(t_req_addr), .t_req_write(t_req_write), .t_req_strb(t_req_strb),
    .t_req_wdata(t_req_wdata), .t_rsp_valid(t_rsp_valid), .t_rsp_data(t_rsp_data),
    .err(err)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  // behavioural reference state
  logic [19:0] model_addr = '0;
  bit          model_err = 0;
  int          req_count = 0;
  logic [19:0] rec_addr;
  logic [3:0]  rec_strb;
  logic [31:0] rec_wdata;
  logic        rec_write;
  int          stall_cfg = 0, lat_cfg = 0;
  int          stall_cnt = 0, rsp_wait = 0;
  bit          rsp_pending = 0;
  logic [31:0] rsp_word;

  function automatic logic [31:0] pattern(input logic [19:0] a);
    return 32'hC3000000 ^ {12'h0, a};
  endfunction

  function automatic bit flash_ok(input logic [1:0] lo, input logic [3:0] be);
    case ({lo, be})
      6'b00_1110, 6'b01_1101, 6'b10_1011, 6'b11_0111,
      6'b00_1100, 6'b10_0011, 6'b00_0000: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // internal target model
  always @(negedge clk) begin
    t_rsp_valid = 1'b0;
    if (rsp_pending) begin
      if (rsp_wait == 0) begin
        t_rsp_valid = 1'b1;
        t_rsp_data  = rsp_word;
        rsp_pending = 0;
      end else rsp_wait--;
    end
    if (t_req_ready) t_req_ready = 1'b0;
    else if (t_req_valid && !rsp_pending) begin
      if (stall_cnt < stall_cfg) stall_cnt++;
      else begin
        t_req_ready = 1'b1;
        stall_cnt = 0;
        req_count++;
        rec_addr = t_req_addr; rec_strb = t_req_strb;
        rec_wdata = t_req_wdata; rec_write = t_req_write;
        if (!t_req_write) begin
          rsp_pending = 1;
          rsp_wait = lat_cfg;
          rsp_word = pattern(t_req_addr);
        end
      end
    end
  end

  // error flag compared with the model on every clock (R6 R7 R10)
  always @(negedge clk)
    if (!rst && !finished) chk(err == model_err, "R10 err vs model", {31'b0, err}, {31'b0, model_err});

  task automatic host(input bit sel, input bit wr, input logic [3:0] be,
                      input logic [31:0] wd, output logic [31:0] rd);
    bit fwd, rg, fl;
    for (int i = 0; i < 200 && !h_ready; i++) @(negedge clk);
    h_valid = 1; h_sel = sel; h_write = wr; h_be_n = be; h_wdata = wd;
    @(posedge clk);
    rg = (model_addr[19:17] == 3'b000);
    fl = model_addr[19];
    fwd = 0;
    if (!sel && wr)
      model_addr = (wd[19:17] == 3'b000) ? {wd[19:2], 2'b00} : wd[19:0];
    else if (sel) begin
      if (!rg && !(fl && flash_ok(model_addr[1:0], be))) model_err = 1;
      else if (fl || !wr || be == 4'b0000) fwd = 1;
    end
    #1;
    @(negedge clk);
    h_valid = 0;
    if (fwd) chk(h_ready == 1'b0, "R9 host stalled while forwarded", {31'b0, h_ready}, 32'h0);
    rd = 'x;
    if (!wr) begin
      for (int i = 0; i < 200 && !h_rvalid; i++) @(negedge clk);
      rd = h_rdata;
    end else begin
      for (int i = 0; i < 200 && !h_ready; i++) @(negedge clk);
    end
  endtask

  task automatic set_ptr(input logic [19:0] a);
    logic [31:0] d;
    host(0, 1, 4'h0, {12'h0, a}, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=0x%08h expected=0x%08h", 32'h1, 32'h0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int n0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(h_ready == 1'b1, "R1 h_ready after reset", {31'b0, h_ready}, 32'h1);
    chk(err == 1'b0 && t_req_valid == 1'b0 && h_rvalid == 1'b0, "R1 idle outputs",
        {29'b0, err, t_req_valid, h_rvalid}, 32'h0);
    host(0, 0, 4'h0, 0, rd);
    chk(rd == 32'h0, "R1 pointer reset value", rd, 32'h0);

    // R2 pointer alignment rule
    set_ptr(20'h00013); host(0, 0, 4'h0, 0, rd);
    chk(rd == 32'h00010, "R2 register-range low bits cleared", rd, 32'h00010);
    set_ptr(20'h80003); host(0, 0, 4'h0, 0, rd);
    chk(rd == 32'h80003, "R2 flash low bits kept", rd, 32'h80003);
    set_ptr(20'h20003); host(0, 0, 4'h0, 0, rd);
    chk(rd == 32'h20003, "R2 undefined low bits kept", rd, 32'h20003);

    // R4 full write in register space, with stall (R9)
    stall_cfg = 3;
    set_ptr(20'h00127);
    n0 = req_count;
    host(1, 1, 4'b0000, 32'hDEADBEEF, rd);
    chk(req_count == n0 + 1, "R4 one request", req_count, n0 + 1);
    chk(rec_addr == 20'h00124 && rec_write, "R4 request address aligned", {12'h0, rec_addr}, 32'h00124);
    chk(rec_strb == 4'hF && rec_wdata == 32'hDEADBEEF, "R4 strobe and data", {rec_strb, rec_wdata[27:0]}, {4'hF, 28'hEADBEEF});
    n0 = req_count;
    host(1, 1, 4'b1100, 32'h11111111, rd);
    chk(req_count == n0 && !err, "R4 short write dropped silently", req_count, n0);

    // R8 register read, any size, with latency
    stall_cfg = 1; lat_cfg = 2;
    set_ptr(20'h00200);
    host(1, 0, 4'b1110, 0, rd);
    chk(rd == pattern(20'h00200), "R8 register read full word", rd, pattern(20'h00200));
    chk(rec_strb == 4'hF && !rec_write, "R8 register read strobe", {28'h0, rec_strb}, 32'hF);
    // R3 register-space top word is forwarded
    set_ptr(20'h1FFFC); n0 = req_count;
    host(1, 0, 4'b0000, 0, rd);
    chk(req_count == n0 + 1 && rd == pattern(20'h1FFFC), "R3 top of register space", rd, pattern(20'h1FFFC));

    // R5 legal flash writes
    stall_cfg = 0; lat_cfg = 0;
    for (int lane = 0; lane < 4; lane++) begin
      logic [3:0] be;
      be = ~(4'b0001 << lane);
      set_ptr(20'h80000 | 20'(lane));
      host(1, 1, be, 32'hA0B0C0D0 + lane, rd);
      chk(rec_addr == (20'h80000 | 20'(lane)) && rec_strb == ~be && rec_write &&
          rec_wdata == 32'hA0B0C0D0 + lane, "R5 flash byte write",
          {rec_addr[7:0], 20'h0, rec_strb}, {6'h0, 2'(lane), 20'h0, ~be});
    end
    set_ptr(20'h80002); host(1, 1, 4'b0011, 32'h5555AAAA, rd);
    chk(rec_addr == 20'h80002 && rec_strb == 4'b1100, "R5 flash upper word", {12'h0, rec_addr}, 32'h80002);
    set_ptr(20'h80000); host(1, 1, 4'b1100, 32'h12345678, rd);
    chk(rec_strb == 4'b0011, "R5 flash lower word", {28'h0, rec_strb}, 32'h3);
    set_ptr(20'h9ABC4); host(1, 1, 4'b0000, 32'h0F0F0F0F, rd);
    chk(rec_addr == 20'h9ABC4 && rec_strb == 4'hF, "R5 flash dword", {12'h0, rec_addr}, 32'h9ABC4);

    // R8 flash byte read returns whole word
    lat_cfg = 3;
    set_ptr(20'h80001); host(1, 0, 4'b1101, 0, rd);
    chk(rd == pattern(20'h80001) && rec_strb == 4'b0010, "R8 flash byte read", rd, pattern(20'h80001));

    // R6 flash misaligned
    n0 = req_count;
    host(1, 1, 4'b1100, 32'h77777777, rd);
    chk(req_count == n0, "R6 misaligned flash write dropped", req_count, n0);
    @(negedge clk);
    chk(err == 1'b1, "R6 err set", {31'b0, err}, 32'h1);
    set_ptr(20'h80002); host(1, 0, 4'b1100, 0, rd);
    chk(rd == 32'hFFFFFFFF && req_count == n0, "R6 misaligned flash read all ones", rd, 32'hFFFFFFFF);

    // R7 undefined region, R3 boundaries
    set_ptr(20'h20000); n0 = req_count;
    host(1, 0, 4'b0000, 0, rd);
    chk(rd == 32'hFFFFFFFF, "R7 undefined read all ones", rd, 32'hFFFFFFFF);
    set_ptr(20'h7FFFC);
    host(1, 1, 4'b0000, 32'h1, rd);
    host(1, 0, 4'b0000, 0, rd);
    chk(req_count == n0 && rd == 32'hFFFFFFFF, "R3 R7 top of undefined span", req_count, n0);

    // R10 stays set after a legal access
    lat_cfg = 0;
    set_ptr(20'h00040); host(1, 0, 4'b0000, 0, rd);
    chk(err == 1'b1 && rd == pattern(20'h00040), "R10 err kept after legal read", {31'b0, err}, 32'h1);

    // reset clears the flag and pointer (R1)
    @(negedge clk);
    rst = 1; model_err = 0; model_addr = '0;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(err == 1'b0 && h_ready == 1'b1, "R1 second reset", {30'b0, err, h_ready}, 32'h1);
    host(0, 0, 4'h0, 0, rd);
    chk(rd == 32'h0, "R1 pointer cleared", rd, 32'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule